// File: doc/BRIEF.md
# Cascaded Interrupt Vector Sequencer

This block joins two eight-line interrupt controllers, a primary and a secondary, into one sixteen-line interrupt system. Each controller's priority resolver lives outside the block. The block sees only each resolver's result: a valid flag and a 3-bit winning line. It also receives each controller's vector base. The secondary feeds the primary through one cascade line on the primary side. When the secondary has a pending line, the block drives a single-cycle pulse toward that cascade input. The primary controller then records the request as an edge.

When the processor strobes an interrupt acknowledge, the block decides in one step which controller is being serviced. It issues single-cycle acknowledge pulses, each carrying the acknowledged line, to the primary, to the secondary, or to both. In the following cycle it returns an 8-bit vector. When a controller has nothing to offer, the block substitutes that controller's spurious line (line 7). The block also holds a trigger-mode register for each controller. Writes to these registers pass through a fixed per-controller mask. A 4-bit global line number can be looked up against these registers to report whether that line is level triggered.

Top module: `cascade_vector_seq`

## Requirements
- R1: One cycle after `sec_valid` is seen to go from 0 to 1, `cascade_pulse` is 1 for exactly one cycle and then returns to 0.
- R2: When an acknowledge finds `pri_valid` low, the vector in the next cycle is `pri_base + 7` (modulo 256), and neither `pri_ack` nor `sec_ack` pulses.
- R3: When an acknowledge finds the primary winning line is not 2, the following happen in the next cycle: `pri_ack` pulses with `pri_ack_line` equal to that line, `sec_ack` stays low, and the vector is `pri_base + line`.
- R4: When an acknowledge finds the primary winning line is 2 and `sec_valid` high, the following happen in the next cycle: `pri_ack` pulses with line 2, `sec_ack` pulses with the secondary line, and the vector is `sec_base + secondary line`.
- R5: When an acknowledge finds the primary winning line is 2 and `sec_valid` low, the following happen in the next cycle: `pri_ack` pulses with line 2, `sec_ack` stays low, and the vector is `sec_base + 7`.
- R6: `vec_valid` is high in the cycle after each cycle with `ack_req` high, and low otherwise. `pri_ack` and `sec_ack` are never high while `vec_valid` is low.
- R7: A trigger-mode write with `trig_sel`=0 loads `trig_data & 0xF8` into `pri_trig`. A write with `trig_sel`=1 loads `trig_data & 0xDE` into `sec_trig`. Either change shows in the next cycle.
- R8: In `glb_line`, bit 3 set selects the secondary and bits 2:0 give the local line. `glb_level` is the selected controller's trigger bit at that local line.
- R9: After reset, every output register is 0, including both trigger registers, `vec_valid`, the acknowledge pulses and `cascade_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pri_valid | input | 1 | Primary resolver has a winning line |
| pri_line | input | 3 | Primary winning line |
| pri_base | input | 8 | Primary vector base |
| sec_valid | input | 1 | Secondary resolver has a winning line |
| sec_line | input | 3 | Secondary winning line |
| sec_base | input | 8 | Secondary vector base |
| ack_req | input | 1 | Processor acknowledge strobe |
| trig_we | input | 1 | Trigger-mode register write enable |
| trig_sel | input | 1 | 0 writes the primary register, 1 writes the secondary register |
| trig_data | input | 8 | Trigger-mode write data |
| glb_line | input | 4 | Global line number to look up |
| vec_out | output | 8 | Vector returned for the acknowledge |
| vec_valid | output | 1 | Vector valid, one cycle after the acknowledge |
| pri_ack | output | 1 | Acknowledge pulse to the primary |
| pri_ack_line | output | 3 | Line acknowledged on the primary |
| sec_ack | output | 1 | Acknowledge pulse to the secondary |
| sec_ack_line | output | 3 | Line acknowledged on the secondary |
| cascade_pulse | output | 1 | Edge pulse toward the primary cascade input |
| pri_trig | output | 8 | Primary trigger-mode register |
| sec_trig | output | 8 | Secondary trigger-mode register |
| glb_level | output | 1 | Trigger bit of the line named by `glb_line` |

## Verification
The bench builds the block with its default parameters: cascade on primary line 2, spurious line 7, and masks 0xF8 and 0xDE. These defaults bring every branch of the acknowledge decision within reach: a missing primary, an ordinary primary line, a cascade with and without a secondary line, and back-to-back acknowledges. The masks make writes of all ones and all zeros show which bits each controller can never set. Global lookups on both sides of bit 3 show the controller selection.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  localparam int LINE_W = 3;
  localparam int VEC_W  = 8;
  localparam int NLINES = 1 << LINE_W;

  typedef struct packed {
    logic              valid;
    logic [LINE_W-1:0] line;
  } res_t;

  // Vector arithmetic: base plus local line, wrapping at the vector width.
  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                              input logic [LINE_W-1:0] line);
    return base + {{(VEC_W-LINE_W){1'b0}}, line};
  endfunction

  // Global line: top bit chooses the secondary controller.
  function automatic logic glb_is_sec(input logic [LINE_W:0] gl);
    return gl[LINE_W];
  endfunction

  function automatic logic [LINE_W-1:0] glb_local(input logic [LINE_W:0] gl);
    return gl[LINE_W-1:0];
  endfunction
endpackage

// File: rtl/cvs_cascade_fwd.sv
module cvs_cascade_fwd (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_valid,
  output logic cascade_pulse
);
  logic sec_valid_q;
  logic sec_rise;

  assign sec_rise = sec_valid & ~sec_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_valid_q   <= 1'b0;
      cascade_pulse <= 1'b0;
    end else begin
      sec_valid_q   <= sec_valid;
      cascade_pulse <= sec_rise;
    end
  end

  // R1
  rise_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_valid) |=> cascade_pulse);
  // R1
  pulse_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_pulse |=> !cascade_pulse);
endmodule

// File: rtl/cvs_trig_regs.sv
module cvs_trig_regs #(
  parameter logic [7:0] PRI_MASK = 8'hF8,
  parameter logic [7:0] SEC_MASK = 8'hDE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_we,
  input  logic       trig_sel,
  input  logic [7:0] trig_data,
  input  logic [3:0] glb_line,
  output logic [7:0] pri_trig,
  output logic [7:0] sec_trig,
  output logic       glb_level
);
  import cvs_pkg::*;

  logic [7:0] regs [2];
  logic [1:0] wr_hit;
  logic       sel_sec;
  logic [2:0] loc;

  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam logic [7:0] MSK = (g == 0) ? PRI_MASK : SEC_MASK;
    assign wr_hit[g] = trig_we && (trig_sel == g[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs[g] <= '0;
      else if (wr_hit[g]) regs[g] <= trig_data & MSK;
    end
  end

  assign pri_trig  = regs[0];
  assign sec_trig  = regs[1];
  assign sel_sec   = glb_is_sec(glb_line);
  assign loc       = glb_local(glb_line);
  assign glb_level = sel_sec ? sec_trig[loc] : pri_trig[loc];

  // R7
  pri_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !trig_sel) |=> pri_trig == ($past(trig_data) & PRI_MASK));
  // R7
  sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_sel) |=> sec_trig == ($past(trig_data) & SEC_MASK));
  // R7
  sec_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_we && trig_sel) |=> $stable(sec_trig));
endmodule

// File: rtl/cvs_ack_decider.sv
module cvs_ack_decider #(
  parameter logic [2:0] CASCADE_LINE = 3'd2,
  parameter logic [2:0] SPUR_LINE    = 3'd7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cvs_pkg::res_t pri_res,
  input  cvs_pkg::res_t sec_res,
  input  logic [7:0]   pri_base,
  input  logic [7:0]   sec_base,
  input  logic         ack_req,
  output logic [7:0]   vec_out,
  output logic         vec_valid,
  output logic         pri_ack,
  output logic [2:0]   pri_ack_line,
  output logic         sec_ack,
  output logic [2:0]   sec_ack_line
);
  import cvs_pkg::*;

  // Named decision events, brought out for the assertions.
  logic       ev_pri_spur;
  logic       ev_pri_plain;
  logic       ev_cascade;
  logic       ev_sec_hit;
  logic       ev_sec_spur;
  logic [7:0] nxt_vec;

  assign ev_pri_spur  = ack_req && !pri_res.valid;
  assign ev_pri_plain = ack_req && pri_res.valid && (pri_res.line != CASCADE_LINE);
  assign ev_cascade   = ack_req && pri_res.valid && (pri_res.line == CASCADE_LINE);
  assign ev_sec_hit   = ev_cascade && sec_res.valid;
  assign ev_sec_spur  = ev_cascade && !sec_res.valid;

  always_comb begin
    nxt_vec = vec_of(pri_base, SPUR_LINE);
    if (ev_pri_plain)     nxt_vec = vec_of(pri_base, pri_res.line);
    else if (ev_sec_hit)  nxt_vec = vec_of(sec_base, sec_res.line);
    else if (ev_sec_spur) nxt_vec = vec_of(sec_base, SPUR_LINE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out      <= '0;
      vec_valid    <= 1'b0;
      pri_ack      <= 1'b0;
      pri_ack_line <= '0;
      sec_ack      <= 1'b0;
      sec_ack_line <= '0;
    end else begin
      vec_valid <= ack_req;
      pri_ack   <= ev_pri_plain | ev_cascade;
      sec_ack   <= ev_sec_hit;
      if (ack_req) vec_out <= nxt_vec;
      if (ev_pri_plain | ev_cascade) pri_ack_line <= pri_res.line;
      if (ev_sec_hit) sec_ack_line <= sec_res.line;
    end
  end

  // R2
  spur_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pri_spur |=> (!pri_ack && !sec_ack && vec_out == $past(pri_base) + 8'(SPUR_LINE)));
  // R3
  plain_no_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pri_plain |=> (pri_ack && !sec_ack));
  // R4
  sec_implies_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ack |-> (pri_ack && pri_ack_line == CASCADE_LINE));
  // R5
  sec_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sec_spur |=> (pri_ack && !sec_ack && vec_out == $past(sec_base) + 8'(SPUR_LINE)));
  // R6
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> vec_valid);
  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !vec_valid);
  // R6
  ack_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_ack || sec_ack) |-> vec_valid);
endmodule

// File: rtl/cascade_vector_seq.sv
module cascade_vector_seq #(
  parameter logic [2:0] CASCADE_LINE = 3'd2,
  parameter logic [2:0] SPUR_LINE    = 3'd7,
  parameter logic [7:0] PRI_MASK     = 8'hF8,
  parameter logic [7:0] SEC_MASK     = 8'hDE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pri_valid,
  input  logic [2:0] pri_line,
  input  logic [7:0] pri_base,
  input  logic       sec_valid,
  input  logic [2:0] sec_line,
  input  logic [7:0] sec_base,
  input  logic       ack_req,
  input  logic       trig_we,
  input  logic       trig_sel,
  input  logic [7:0] trig_data,
  input  logic [3:0] glb_line,
  output logic [7:0] vec_out,
  output logic       vec_valid,
  output logic       pri_ack,
  output logic [2:0] pri_ack_line,
  output logic       sec_ack,
  output logic [2:0] sec_ack_line,
  output logic       cascade_pulse,
  output logic [7:0] pri_trig,
  output logic [7:0] sec_trig,
  output logic       glb_level
);
  import cvs_pkg::*;

  res_t pri_res;
  res_t sec_res;

  assign pri_res = '{valid: pri_valid, line: pri_line};
  assign sec_res = '{valid: sec_valid, line: sec_line};

  cvs_cascade_fwd u_cas (
    .clk(clk), .rst_n(rst_n), .sec_valid(sec_valid), .cascade_pulse(cascade_pulse)
  );

  cvs_ack_decider #(.CASCADE_LINE(CASCADE_LINE), .SPUR_LINE(SPUR_LINE)) u_ack (
    .clk(clk), .rst_n(rst_n), .pri_res(pri_res), .sec_res(sec_res),
    .pri_base(pri_base), .sec_base(sec_base), .ack_req(ack_req),
    .vec_out(vec_out), .vec_valid(vec_valid), .pri_ack(pri_ack),
    .pri_ack_line(pri_ack_line), .sec_ack(sec_ack), .sec_ack_line(sec_ack_line)
  );

  cvs_trig_regs #(.PRI_MASK(PRI_MASK), .SEC_MASK(SEC_MASK)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_sel(trig_sel),
    .trig_data(trig_data), .glb_line(glb_line), .pri_trig(pri_trig),
    .sec_trig(sec_trig), .glb_level(glb_level)
  );
endmodule

// File: tb/cascade_vector_seq_test.sv
module cascade_vector_seq_test;
  logic clk = 0, rst_n = 0;
  logic pri_valid = 0, sec_valid = 0, ack_req = 0, trig_we = 0, trig_sel = 0;
  logic [2:0] pri_line = 0, sec_line = 0;
  logic [7:0] pri_base = 8'h08, sec_base = 8'h70, trig_data = 0;
  logic [3:0] glb_line = 0;
  logic [7:0] vec_out, pri_trig, sec_trig;
  logic vec_valid, pri_ack, sec_ack, cascade_pulse, glb_level;
  logic [2:0] pri_ack_line, sec_ack_line;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [7:0] vec; logic pa; logic [2:0] pl; logic sa; logic [2:0] sl; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  cascade_vector_seq uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: present one acknowledge and push the expected outcome.
  task automatic do_ack(input logic pv, input logic [2:0] pl, input logic sv, input logic [2:0] sl);
    exp_t e;
    @(negedge clk);
    pri_valid = pv; pri_line = pl; sec_valid = sv; sec_line = sl; ack_req = 1;
    if (!pv) begin
      e = '{pri_base + 8'd7, 0, 0, 0, 0, "R2"};
    end else if (pl != 3'd2) begin
      e = '{pri_base + 8'(pl), 1, pl, 0, 0, "R3"};
    end else if (sv) begin
      e = '{sec_base + 8'(sl), 1, 3'd2, 1, sl, "R4"};
    end else begin
      e = '{sec_base + 8'd7, 1, 3'd2, 0, 0, "R5"};
    end
    q.push_back(e);
  endtask

  // Monitor: compare at the negedge after each registered result.
  always @(negedge clk) if (rst_n && !done) begin
    if (vec_valid) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R6 unexpected vec_valid", 1, 0);
      else begin
        e = q.pop_front();
        chk(vec_out == e.vec, {e.tag, " vector"}, vec_out, e.vec);
        chk(pri_ack == e.pa && (!e.pa || pri_ack_line == e.pl), {e.tag, " pri_ack"},
            {pri_ack, pri_ack_line}, {e.pa, e.pl});
        chk(sec_ack == e.sa && (!e.sa || sec_ack_line == e.sl), {e.tag, " sec_ack"},
            {sec_ack, sec_ack_line}, {e.sa, e.sl});
      end
    end else if (pri_ack || sec_ack) chk(0, "R6 ack without vec_valid", 1, 0);
  end

  task automatic idle(input int n);
    @(negedge clk); ack_req = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(vec_out == 0 && !vec_valid && !pri_ack && !sec_ack && !cascade_pulse, "R9 outputs", vec_out, 0);
    chk(pri_trig == 0 && sec_trig == 0, "R9 trig", {pri_trig, sec_trig}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!vec_valid, "R6 idle after reset", vec_valid, 0);

    // R2 R3 R4 R5 single acknowledges
    do_ack(0, 3'd3, 0, 0); idle(2);
    do_ack(1, 3'd0, 0, 0); idle(2);
    do_ack(1, 3'd5, 1, 3'd1); idle(2);
    do_ack(1, 3'd2, 1, 3'd6); idle(2);
    do_ack(1, 3'd2, 0, 3'd4); idle(2);
    // R6 back-to-back acknowledges, other bases
    pri_base = 8'hF8; sec_base = 8'hA0;
    do_ack(1, 3'd7, 0, 0);
    do_ack(0, 0, 1, 3'd3);
    do_ack(1, 3'd2, 1, 3'd7);
    do_ack(1, 3'd2, 0, 0);
    idle(3);
    chk(q.size() == 0, "R6 all results returned", q.size(), 0);

    // R1 cascade pulse
    @(negedge clk); sec_valid = 0;
    @(negedge clk); chk(!cascade_pulse, "R1 quiet", cascade_pulse, 0);
    sec_valid = 1;
    @(negedge clk); chk(cascade_pulse, "R1 pulse", cascade_pulse, 1);
    @(negedge clk); chk(!cascade_pulse, "R1 falls", cascade_pulse, 0);
    @(negedge clk); chk(!cascade_pulse, "R1 held level no pulse", cascade_pulse, 0);

    // R7 masked writes
    trig_we = 1; trig_sel = 0; trig_data = 8'hFF;
    @(negedge clk); chk(pri_trig == 8'hF8, "R7 pri mask", pri_trig, 8'hF8);
    chk(sec_trig == 8'h00, "R7 sec untouched", sec_trig, 0);
    trig_sel = 1;
    @(negedge clk); chk(sec_trig == 8'hDE, "R7 sec mask", sec_trig, 8'hDE);
    trig_sel = 0; trig_data = 8'h07;
    @(negedge clk); chk(pri_trig == 8'h00, "R7 pri low bits", pri_trig, 0);
    trig_data = 8'h18;
    @(negedge clk); trig_we = 0;
    chk(pri_trig == 8'h18, "R7 pri write", pri_trig, 8'h18);

    // R8 global lookup: pri=0x18, sec=0xDE
    glb_line = 4'd3;  #1 chk(glb_level == 1, "R8 pri line3", glb_level, 1);
    glb_line = 4'd0;  #1 chk(glb_level == 0, "R8 pri line0", glb_level, 0);
    glb_line = 4'd11; #1 chk(glb_level == 1, "R8 sec line3", glb_level, 1);
    glb_line = 4'd8;  #1 chk(glb_level == 0, "R8 sec line0", glb_level, 0);
    glb_line = 4'd13; #1 chk(glb_level == 0, "R8 sec line5", glb_level, 0);
    glb_line = 4'd4;  #1 chk(glb_level == 1, "R8 pri line4", glb_level, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule